// File: doc/BRIEF.md
# Banked Interrupt Controller

This controller collects a wide set of external interrupt lines and groups them into banks of eight. Every line has four per-bit controls spread across four byte registers in its bank: a pending status bit, a mask (enable) bit, a sensing-mode bit choosing level or edge detection, and a polarity bit choosing which level or edge is active. Incoming lines are synchronized, qualified by polarity and mode, and recorded in the status registers.

A single request output tells the processor that at least one enabled line is pending. Software reads a vector register to learn which line to service. The vector holds the lowest-numbered enabled pending line plus a fixed offset of 0x10. Line 0 shares its code with "nothing pending", so it never yields a serviceable vector. Software acknowledges an edge-sensed line by writing a one to its status bit.

Top module: `intc_multibank`

## Requirements
- R1: Line n sits in bank n/8 at bit n%8. The byte address is bank*4 + sel, where sel 0 is status, 1 is enable, 2 is mode and 3 is polarity. The vector register is at address NUM_BANKS*4 (84 by default). Any other address reads 0.
- R2: After reset, every status, enable, mode and polarity bit is 0, and irq_req is low.
- R3: With mode bit 0 (level), the status bit follows the polarity-qualified synchronized input. Writing a one to that status bit has no lasting effect while the input stays active.
- R4: With mode bit 1 (edge), a qualified edge sets the status bit and the bit stays set. Writing a status byte clears exactly the bits written as one.
- R5: With polarity bit 0, the active condition is a high level or a rising edge. With polarity bit 1, it is a low level or a falling edge.
- R6: irq_req is high exactly when some line has both its status bit and its enable bit set. A pending line that is disabled does not raise it.
- R7: The vector register reads 0x10 plus the lowest-numbered line that is both pending and enabled. When no such line exists it reads 0x10, the same value that line 0 produces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_BANKS*8 | Asynchronous interrupt inputs |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are those where mode and polarity interact with an input that is already active. Examples are switching polarity while a line is high, which must not create an edge, and acknowledging a level line whose input is still asserted. The stimulus reaches these states by holding the input steady, rewriting the control bits around it, and then reading status back over the bus. Priority is exercised by making several lines pending at once across distant banks and retiring them one at a time. Line 0 and the last line are included in that set.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int BANK_W = 8;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_MODE   = 2'd2,
        SEL_POL    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BANK_W-1:0] status;
        logic [BANK_W-1:0] enable;
        logic [BANK_W-1:0] mode;
        logic [BANK_W-1:0] pol;
    } bank_regs_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= async_in;
            sync_out <= stage1_q;
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] line_sync,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [BANK_W-1:0] wr_data,
    output bank_regs_t        regs
);
    bank_regs_t        r_q;
    logic [BANK_W-1:0] qual;
    logic [BANK_W-1:0] qual_prev_q;
    logic [BANK_W-1:0] edge_hit;
    logic [BANK_W-1:0] clr_mask;

    // Polarity flips the sense; edge is a 0->1 transition of the qualified level
    assign qual     = line_sync ^ r_q.pol;
    assign edge_hit = qual & ~qual_prev_q;
    assign clr_mask = (wr_en && wr_sel == SEL_STATUS) ? wr_data : '0;
    assign regs     = r_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q         <= '0;
            qual_prev_q <= '0;
        end else begin
            qual_prev_q <= qual;
            for (int b = 0; b < BANK_W; b++) begin
                if (!r_q.mode[b])
                    r_q.status[b] <= qual[b];
                else if (edge_hit[b])
                    r_q.status[b] <= 1'b1;
                else if (clr_mask[b])
                    r_q.status[b] <= 1'b0;
            end
            if (wr_en) begin
                case (wr_sel)
                    SEL_ENABLE: r_q.enable <= wr_data;
                    SEL_MODE:   r_q.mode   <= wr_data;
                    SEL_POL:    r_q.pol    <= wr_data;
                    default:    ;
                endcase
            end
        end
    end

    assert_reset_clear_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (r_q == '0));

    for (genvar b = 0; b < BANK_W; b++) begin : g_chk
        assert_level_follow_R3: assert property (@(posedge clk) disable iff (rst)
            !r_q.mode[b] |=> (r_q.status[b] == $past(qual[b])));
        assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (rst)
            (r_q.mode[b] && r_q.status[b] && !clr_mask[b]) |=> r_q.status[b]);
        assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
            (r_q.mode[b] && clr_mask[b] && !edge_hit[b]) |=> !r_q.status[b]);
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] grant;

    // Scan high to low so the lowest set index is written last
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

    assign grant = req & (~req + 1'b1);

    assert_lowest_first_R7: assert property (@(posedge clk) disable iff (rst)
        valid |-> (grant == (N'(1) << idx)));
    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
endmodule

// File: rtl/intc_multibank.sv
module intc_multibank
    import intc_pkg::*;
#(
    parameter int NUM_BANKS  = 21,
    parameter int VEC_OFFSET = 16,
    parameter int NUM_LINES  = NUM_BANKS * BANK_W,
    parameter int ADDR_W     = $clog2(NUM_BANKS * 4 + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 irq_req
);
    localparam int IDX_W    = $clog2(NUM_LINES);
    localparam int BIDX_W   = ADDR_W - 2;
    localparam int VEC_ADDR = NUM_BANKS * 4;

    logic [NUM_LINES-1:0] lines_sync;
    logic [NUM_LINES-1:0] active;
    logic [BIDX_W-1:0]    bank_sel;
    reg_sel_e             reg_sel;
    bank_regs_t           regs [NUM_BANKS];
    logic                 vec_valid;
    logic [IDX_W-1:0]     vec_idx;
    logic [7:0]           vector;

    assign bank_sel = bus_addr[ADDR_W-1:2];
    assign reg_sel  = reg_sel_e'(bus_addr[1:0]);

    intc_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_lines),
        .sync_out (lines_sync)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        intc_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .line_sync (lines_sync[g*BANK_W +: BANK_W]),
            .wr_en     (bus_wr && (bank_sel == BIDX_W'(g))),
            .wr_sel    (reg_sel),
            .wr_data   (bus_wdata),
            .regs      (regs[g])
        );
        assign active[g*BANK_W +: BANK_W] = regs[g].status & regs[g].enable;
    end

    intc_prio #(.N(NUM_LINES), .IDX_W(IDX_W)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .req   (active),
        .valid (vec_valid),
        .idx   (vec_idx)
    );

    assign irq_req = |active;
    assign vector  = vec_valid ? 8'(VEC_OFFSET + int'(vec_idx)) : 8'(VEC_OFFSET);

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_BANKS; g++) begin
            if (bank_sel == BIDX_W'(g)) begin
                case (reg_sel)
                    SEL_STATUS: bus_rdata = regs[g].status;
                    SEL_ENABLE: bus_rdata = regs[g].enable;
                    SEL_MODE:   bus_rdata = regs[g].mode;
                    default:    bus_rdata = regs[g].pol;
                endcase
            end
        end
        if (bus_addr == ADDR_W'(VEC_ADDR))
            bus_rdata = vector;
    end

    assert_req_matches_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req == vec_valid);
    assert_req_low_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_req);
endmodule

// File: tb/intc_multibank_tb.sv
module intc_multibank_tb;
    localparam int NB    = 21;
    localparam int NL    = NB * 8;
    localparam int AW    = $clog2(NB * 4 + 1);
    localparam int VADDR = NB * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_lines = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          irq_req;

    always #2.5 clk = ~clk;

    intc_multibank #(.NUM_BANKS(NB)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req)
    );

    typedef struct {
        bit         is_req;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    total = 0;
    int    fails = 0;
    bit    done  = 1'b0;

    // Monitor: compares each queued expectation with the live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = it.is_req ? {7'b0, irq_req} : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input int addr, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = AW'(addr);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic exp_rd(input int addr, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = AW'(addr);
        #1;
        it.is_req = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        -> sample_ev;
    endtask

    task automatic exp_req(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        #1;
        it.is_req = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
        q.push_back(it);
        -> sample_ev;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        exp_rd(4, 8'h00, "R2 status");
        exp_rd(5, 8'h00, "R2 enable");
        exp_rd(6, 8'h00, "R2 mode");
        exp_rd(7, 8'h00, "R2 polarity");
        exp_req(1'b0, "R2 irq_req");
        exp_rd(VADDR, 8'h10, "R7 vector idle");
        exp_rd(VADDR + 3, 8'h00, "R1 unmapped address");

        // R3 level, line 9 (bank 1 bit 1)
        wr(5, 8'h02);
        exp_rd(5, 8'h02, "R1 enable readback");
        irq_lines[9] = 1'b1;
        settle();
        exp_rd(4, 8'h02, "R3 level status");
        exp_req(1'b1, "R6 req on");
        exp_rd(VADDR, 8'h19, "R7 vector line 9");
        wr(4, 8'h02);
        exp_rd(4, 8'h02, "R3 w1c no lasting effect");
        irq_lines[9] = 1'b0;
        settle();
        exp_rd(4, 8'h00, "R3 level drop");
        exp_req(1'b0, "R6 req off");

        // R4 edge, line 17 (bank 2 bit 1)
        wr(10, 8'h02);
        wr(9, 8'h02);
        irq_lines[17] = 1'b1;
        settle();
        exp_rd(8, 8'h02, "R4 rising edge latched");
        wr(8, 8'h01);
        exp_rd(8, 8'h02, "R4 zero bits keep state");
        wr(8, 8'h02);
        settle();
        exp_rd(8, 8'h00, "R4 cleared while input high");
        // R5 switch to falling polarity while line high: no edge
        wr(11, 8'h02);
        settle();
        exp_rd(8, 8'h00, "R5 polarity change no edge");
        irq_lines[17] = 1'b0;
        settle();
        exp_rd(8, 8'h02, "R5 falling edge latched");
        wr(8, 8'h02);
        exp_req(1'b0, "R4 cleared req");

        // R5 active-low level, line 30 (bank 3 bit 6), masked first
        wr(15, 8'h40);
        settle();
        exp_rd(12, 8'h40, "R5 active-low level");
        exp_req(1'b0, "R6 masked pending");
        exp_rd(VADDR, 8'h10, "R7 masked not reported");
        wr(13, 8'h40);
        exp_rd(VADDR, 8'h2E, "R7 vector line 30");
        wr(13, 8'h00);
        wr(15, 8'h00);
        settle();
        exp_rd(12, 8'h00, "R5 polarity restored");

        // R7 priority: lines 40 (bank 5 bit 0) and 100 (bank 12 bit 4)
        wr(22, 8'h01); wr(21, 8'h01);
        wr(50, 8'h10); wr(49, 8'h10);
        irq_lines[40] = 1'b1; irq_lines[100] = 1'b1;
        settle();
        irq_lines[40] = 1'b0; irq_lines[100] = 1'b0;
        settle();
        exp_rd(VADDR, 8'h38, "R7 lowest wins");
        wr(20, 8'h01);
        exp_rd(VADDR, 8'h74, "R7 next line 100");
        wr(48, 8'h10);
        exp_req(1'b0, "R6 all retired");

        // R7 line 0 and last line
        wr(1, 8'h01); wr(81, 8'h80);
        irq_lines[0] = 1'b1; irq_lines[167] = 1'b1;
        settle();
        exp_req(1'b1, "R6 line 0 raises req");
        exp_rd(VADDR, 8'h10, "R7 line 0 reads as none");
        irq_lines[0] = 1'b0;
        settle();
        exp_rd(80, 8'h80, "R1 last line bank 20 bit 7");
        exp_rd(VADDR, 8'hB7, "R7 vector line 167");

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule